// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from up to 64 sources, latches each in a flag bit, and picks one pending source to be serviced next. Each source has an enable bit and a 5-bit priority. Some sources are persistent, meaning level-sensitive. The rest are non-persistent, meaning edge-triggered. A group of external pins passes through a two-flop synchronizer and then an edge detector whose edge is selected per pin. The winning source number is shown in a status register, and a registered request line goes to the processor.

Software reaches every register through a flat 32-bit word bus with combinational reads. Each register on the 16-byte grid has three write addresses: the base, which replaces the register; base+0x4, which clears the bits written as 1; and base+0x8, which sets them. Each source also owns a plain 32-bit storage word, typically holding its handler offset.

Top module: `vic_top`

## Requirements
- R1: After synchronous reset, all flag, enable, priority, polarity and status bits read 0 and `irq_o` is low.
- R2: The register map is as follows.
  - Polarity register: 0x000.
  - Status register: 0x020.
  - Flag registers: from 0x040.
  - Enable registers: from 0x0C0.
  - Priority registers: from 0x140.
  - Flag, enable and priority registers are spaced 0x10 apart.
  - Source n uses flag and enable register n/32, bit n%32.
  - Reads of the +0x4 and +0x8 addresses return the base register.
- R3: Writing to base+0x0 replaces the register. Writing to base+0x4 clears exactly the bits written as 1. Writing to base+0x8 sets exactly the bits written as 1. Bits written as 0 through +0x4 or +0x8 are unchanged.
- R4: Source n has its priority in register n/4, bits (n%4)*8+4 down to (n%4)*8. Bits 4:2 of the field are the major level and bits 1:0 are the sub-level. The three upper bits of each byte lane read 0.
- R5: The status register's low 8 bits hold the winning source. The winner is the pending, enabled source with the largest 5-bit priority value. On a tie, the lowest source number wins. A priority of 0 never wins. The status register reads 0 when no source qualifies.
- R6: `irq_o` is high exactly when, in the previous cycle, some source had its flag set, its enable set and a nonzero priority. The status register updates in the same cycle as `irq_o`.
- R7: A persistent source sets its flag in every cycle that its input is high. A software clear has no effect while the input is high. The flag stays set after the input drops, until software clears it.
- R8: A non-persistent source sets its flag once per 0-to-1 transition of its input. If the input is held high after a clear, the flag does not set again.
- R9: External pin i sets the flag of source 56+i. Bit i of the polarity register selects the edge: 1 for rising, 0 for falling. The opposite edge has no effect. The flag becomes visible three clock edges after the pin changes. `src_req` bits 56..63 are ignored.
- R10: Source n owns a plain read/write word at 0x540+4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address for read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| src_req | input | 64 | Internal source request lines |
| ext_pin | input | 8 | Asynchronous external interrupt pins |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench first targets arbitration corners. It checks a priority tie between two sources, the raising of one priority above the other, and the dropping of a priority to zero. A faulty arbiter would report the higher-numbered source or let a zero-priority source win. The bench clears a level source while its input is still high and expects the flag to remain. It clears an edge source whose input is held high and expects the flag to stay clear. It applies the opposite pin edge and expects no flag. These checks catch a flag that ignores the input state, re-arms on a held level, or detects both edges. Finally, the external pin latency is sampled cycle by cycle, so a missing or extra synchronizer stage is caught.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned BUS_AW = 12;
    localparam int unsigned BUS_DW = 32;
    localparam int unsigned PRI_W  = 5;
    localparam int unsigned VEC_W  = 8;

    localparam logic [BUS_AW-1:0] A_CTRL = 12'h000;
    localparam logic [BUS_AW-1:0] A_STAT = 12'h020;
    localparam logic [BUS_AW-1:0] A_FLAG = 12'h040;
    localparam logic [BUS_AW-1:0] A_EN   = 12'h0C0;
    localparam logic [BUS_AW-1:0] A_PRI  = 12'h140;
    localparam logic [BUS_AW-1:0] A_OFF  = 12'h540;

    typedef enum logic [1:0] {OP_WRITE, OP_CLR, OP_SET, OP_NONE} wr_op_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } arb_res_t;

    function automatic wr_op_e op_of(input logic [3:0] low);
        case (low)
            4'h0:    return OP_WRITE;
            4'h4:    return OP_CLR;
            4'h8:    return OP_SET;
            default: return OP_NONE;
        endcase
    endfunction

    function automatic logic [BUS_DW-1:0] apply_op(input wr_op_e op,
                                                   input logic [BUS_DW-1:0] cur,
                                                   input logic [BUS_DW-1:0] wd);
        case (op)
            OP_WRITE: return wd;
            OP_CLR:   return cur & ~wd;
            OP_SET:   return cur | wd;
            default:  return cur;
        endcase
    endfunction
endpackage

// File: rtl/vic_ext_edge.sv
module vic_ext_edge #(
    parameter int unsigned N_EXT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_EXT-1:0] pin,
    input  logic [N_EXT-1:0] rise_sel,
    output logic [N_EXT-1:0] pulse
);
    for (genvar i = 0; i < N_EXT; i++) begin : g_pin
        logic s1_q, s2_q, prev_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q   <= 1'b0;
                s2_q   <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                s1_q   <= pin[i];
                s2_q   <= s1_q;
                prev_q <= s2_q;
            end
        end
        assign pulse[i] = rise_sel[i] ? (s2_q & ~prev_q) : (~s2_q & prev_q);
    end
endmodule

// File: rtl/vic_src_flags.sv
module vic_src_flags #(
    parameter int unsigned     N          = 64,
    parameter int unsigned     N_EXT      = 8,
    parameter int unsigned     EXT0       = 56,
    parameter logic [N-1:0]    LEVEL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     src_req,
    input  logic [N_EXT-1:0] ext_pulse,
    input  logic [N-1:0]     sw_wen,
    input  logic [N-1:0]     sw_val,
    output logic [N-1:0]     flags
);
    logic [N-1:0] hw_set;

    for (genvar i = 0; i < N; i++) begin : g_src
        if (i >= EXT0 && i < EXT0 + N_EXT) begin : g_ext
            logic unused_req;
            assign unused_req = src_req[i];
            assign hw_set[i]  = ext_pulse[i-EXT0];
        end else if (LEVEL_MASK[i]) begin : g_level
            assign hw_set[i] = src_req[i];
        end else begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= src_req[i];
            end
            assign hw_set[i] = src_req[i] & ~prev_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            for (int i = 0; i < N; i++)
                flags[i] <= (sw_wen[i] ? sw_val[i] : flags[i]) | hw_set[i];
        end
    end
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int unsigned N = 64
) (
    input  logic [N-1:0]            flags,
    input  logic [N-1:0]            en,
    input  logic [N-1:0][PRI_W-1:0] pri,
    output arb_res_t                res
);
    logic [PRI_W-1:0] best_p;
    logic [VEC_W-1:0] best_i;

    always_comb begin
        best_p = '0;
        best_i = '0;
        for (int i = 0; i < N; i++) begin
            if (flags[i] && en[i] && (pri[i] > best_p)) begin
                best_p = pri[i];
                best_i = VEC_W'(i);
            end
        end
        res.valid = (best_p != '0);
        res.vec   = best_i;
    end
endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int unsigned       NUM_SRC    = 64,
    parameter int unsigned       NUM_EXT    = 8,
    parameter int unsigned       OFF_W      = 32,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 64'h0000_FFFF_0000_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   src_req,
    input  logic [NUM_EXT-1:0]   ext_pin,
    output logic                 irq_o
);
    localparam int unsigned NUM_WREG = NUM_SRC / 32;
    localparam int unsigned NUM_PREG = NUM_SRC / 4;
    localparam int unsigned EXT0     = NUM_SRC - NUM_EXT;

    wr_op_e                          op;
    logic [NUM_EXT-1:0]              pol_q;
    logic [NUM_SRC-1:0]              en_q;
    logic [NUM_SRC-1:0][PRI_W-1:0]   pri_q;
    logic [OFF_W-1:0]                off_q [NUM_SRC];
    logic [NUM_SRC-1:0]              flags_q;
    logic [NUM_SRC-1:0]              flag_wen, flag_wval;
    logic [NUM_EXT-1:0]              ext_pulse;
    logic [VEC_W-1:0]                vec_q;
    logic                            irq_q;
    arb_res_t                        arb;

    assign op = bus_we ? op_of(bus_addr[3:0]) : OP_NONE;

    function automatic logic [BUS_DW-1:0] pri_word(input logic [NUM_SRC-1:0][PRI_W-1:0] p,
                                                   input int unsigned k);
        logic [BUS_DW-1:0] w;
        w = '0;
        for (int j = 0; j < 4; j++) w[j*8 +: PRI_W] = p[k*4+j];
        return w;
    endfunction

    // control (edge polarity) register
    always_ff @(posedge clk) begin
        logic [BUS_DW-1:0] nxt;
        if (rst) begin
            pol_q <= '0;
        end else if (op != OP_NONE && bus_addr[11:4] == A_CTRL[11:4]) begin
            nxt   = apply_op(op, BUS_DW'(pol_q), bus_wdata);
            pol_q <= nxt[NUM_EXT-1:0];
        end
    end

    // enable registers
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else begin
            for (int k = 0; k < NUM_WREG; k++)
                if (op != OP_NONE && bus_addr[11:4] == A_EN[11:4] + 8'(k))
                    en_q[k*32 +: 32] <= apply_op(op, en_q[k*32 +: 32], bus_wdata);
        end
    end

    // priority registers, one source per byte lane
    always_ff @(posedge clk) begin
        logic [BUS_DW-1:0] nxt;
        if (rst) begin
            pri_q <= '0;
        end else begin
            for (int k = 0; k < NUM_PREG; k++) begin
                if (op != OP_NONE && bus_addr[11:4] == A_PRI[11:4] + 8'(k)) begin
                    nxt = apply_op(op, pri_word(pri_q, k), bus_wdata);
                    for (int j = 0; j < 4; j++) pri_q[k*4+j] <= nxt[j*8 +: PRI_W];
                end
            end
        end
    end

    // per-source offset words, word addressed, no aliases
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NUM_SRC; n++) off_q[n] <= '0;
        end else if (bus_we) begin
            for (int n = 0; n < NUM_SRC; n++)
                if (bus_addr[11:2] == A_OFF[11:2] + 10'(n) && bus_addr[1:0] == 2'b00)
                    off_q[n] <= bus_wdata[OFF_W-1:0];
        end
    end

    // software view of flag writes
    always_comb begin
        flag_wen  = '0;
        flag_wval = '0;
        for (int k = 0; k < NUM_WREG; k++) begin
            if (op != OP_NONE && bus_addr[11:4] == A_FLAG[11:4] + 8'(k)) begin
                flag_wen[k*32 +: 32]  = '1;
                flag_wval[k*32 +: 32] = apply_op(op, flags_q[k*32 +: 32], bus_wdata);
            end
        end
    end

    vic_ext_edge #(.N_EXT(NUM_EXT)) u_ext (
        .clk(clk), .rst(rst), .pin(ext_pin), .rise_sel(pol_q), .pulse(ext_pulse)
    );

    vic_src_flags #(.N(NUM_SRC), .N_EXT(NUM_EXT), .EXT0(EXT0), .LEVEL_MASK(LEVEL_MASK)) u_flags (
        .clk(clk), .rst(rst), .src_req(src_req), .ext_pulse(ext_pulse),
        .sw_wen(flag_wen), .sw_val(flag_wval), .flags(flags_q)
    );

    vic_arbiter #(.N(NUM_SRC)) u_arb (
        .flags(flags_q), .en(en_q), .pri(pri_q), .res(arb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_q <= '0;
            irq_q <= 1'b0;
        end else begin
            vec_q <= arb.valid ? arb.vec : '0;
            irq_q <= arb.valid;
        end
    end

    assign irq_o = irq_q;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr[11:4] == A_CTRL[11:4]) bus_rdata = BUS_DW'(pol_q);
        if (bus_addr[11:4] == A_STAT[11:4]) bus_rdata = BUS_DW'(vec_q);
        for (int k = 0; k < NUM_WREG; k++) begin
            if (bus_addr[11:4] == A_FLAG[11:4] + 8'(k)) bus_rdata = flags_q[k*32 +: 32];
            if (bus_addr[11:4] == A_EN[11:4] + 8'(k))   bus_rdata = en_q[k*32 +: 32];
        end
        for (int k = 0; k < NUM_PREG; k++)
            if (bus_addr[11:4] == A_PRI[11:4] + 8'(k)) bus_rdata = pri_word(pri_q, k);
        for (int n = 0; n < NUM_SRC; n++)
            if (bus_addr[11:2] == A_OFF[11:2] + 10'(n) && bus_addr[1:0] == 2'b00)
                bus_rdata = BUS_DW'(off_q[n]);
    end
endmodule

// File: rtl/vic_checker.sv
module vic_checker
    import vic_pkg::*;
#(
    parameter int unsigned  N     = 64,
    parameter int unsigned  EXT0  = 56,
    parameter logic [N-1:0] LVL   = '0
) (
    input logic                clk,
    input logic                rst,
    input logic [N-1:0]        flags,
    input logic [N-1:0]        en,
    input logic [N-1:0][PRI_W-1:0] pri,
    input logic [N-1:0]        src_req,
    input logic [VEC_W-1:0]    vec,
    input logic                irq
);
    localparam int unsigned IDX_W = $clog2(N);

    logic [N-1:0]            elig_q;
    logic [N-1:0][PRI_W-1:0] pri_s;
    logic                    order_bad;
    logic [IDX_W-1:0]        vi;

    always_ff @(posedge clk) begin
        if (rst) begin
            elig_q <= '0;
            pri_s  <= '0;
        end else begin
            for (int i = 0; i < N; i++) elig_q[i] <= flags[i] & en[i] & (pri[i] != '0);
            pri_s <= pri;
        end
    end

    assign vi = vec[IDX_W-1:0];

    always_comb begin
        order_bad = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (elig_q[i] && ((pri_s[i] > pri_s[vi]) ||
                              (pri_s[i] == pri_s[vi] && IDX_W'(i) < vi)))
                order_bad = 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (flags == '0 && !irq && vec == '0)); // R1
    AST_IRQ_BACKED: assert property (@(posedge clk) disable iff (rst)
        irq |-> elig_q[vi]); // R6
    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
        (elig_q == '0) |-> !irq); // R6
    AST_VEC_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !irq |-> (vec == '0)); // R5
    AST_ARB_ORDER: assert property (@(posedge clk) disable iff (rst)
        irq |-> !order_bad); // R5

    for (genvar i = 0; i < N; i++) begin : g_lvl
        if (LVL[i] && i < EXT0) begin : g_on
            AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(src_req[i])) |-> flags[i]); // R7
        end
    end
endmodule

bind vic_top vic_checker #(.N(NUM_SRC), .EXT0(NUM_SRC - NUM_EXT), .LVL(LEVEL_MASK)) u_chk (
    .clk(clk), .rst(rst), .flags(flags_q), .en(en_q), .pri(pri_q),
    .src_req(src_req), .vec(vec_q), .irq(irq_q)
);

// File: tb/tb_vic_top.sv
`timescale 1ns/1ps
module tb_vic_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_req = '0;
    logic [7:0]  ext_pin = '0;
    logic        irq_o;

    vic_top dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .ext_pin(ext_pin), .irq_o(irq_o)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit          is_irq;
        logic [11:0] addr;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sq[$];
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        exp_t        e;
        logic [31:0] got;
        while (sq.size() > 0) begin
            e   = sq.pop_front();
            got = e.is_irq ? {31'b0, irq_o} : bus_rdata;
            n_run++;
            if (got !== e.exp) begin
                n_fail++;
                $display("FAIL %s addr=%h actual=%h expected=%h", e.tag, e.addr, got, e.exp);
            end
        end
    end

    task automatic expect_rd(input logic [11:0] ad, input logic [31:0] ex, input string tag);
        bus_addr = ad;
        sq.push_back('{1'b0, ad, ex, tag});
        @(negedge clk); #1;
    endtask

    task automatic expect_irq(input logic ex, input string tag);
        sq.push_back('{1'b1, 12'h0, {31'b0, ex}, tag});
        @(negedge clk); #1;
    endtask

    task automatic wr(input logic [11:0] ad, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = ad; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        expect_rd(12'h000, 32'h0, "R1 ctrl");
        expect_rd(12'h020, 32'h0, "R1 status");
        expect_rd(12'h040, 32'h0, "R1 flag0");
        expect_rd(12'h0C0, 32'h0, "R1 en0");
        expect_rd(12'h140, 32'h0, "R1 pri0");
        expect_irq(1'b0, "R1 irq");

        // R4 lane packing and R3 aliases on a priority register
        wr(12'h140, 32'hFFFF_FFFF);
        expect_rd(12'h140, 32'h1F1F_1F1F, "R4 lanes 5 bits");
        wr(12'h144, 32'h0000_1F00);
        expect_rd(12'h140, 32'h1F1F_001F, "R3 clear alias");
        wr(12'h148, 32'h0000_0300);
        expect_rd(12'h148, 32'h1F1F_031F, "R3 set alias, R2 alias read");
        wr(12'h140, 32'h0000_0000);
        expect_rd(12'h140, 32'h0, "R3 base replace");

        // R10 offset words
        wr(12'h63C, 32'hDEAD_BEEF);
        wr(12'h540, 32'h1234_5678);
        expect_rd(12'h63C, 32'hDEAD_BEEF, "R10 word 63");
        expect_rd(12'h540, 32'h1234_5678, "R10 word 0");

        // R8 edge source 5, priority 8 in lane 1 of register 1
        wr(12'h0C8, 32'h0000_0020);
        wr(12'h150, 32'h0000_0800);
        src_req[5] = 1'b1;
        tick(3);
        expect_rd(12'h040, 32'h0000_0020, "R8 edge sets flag");
        expect_rd(12'h020, 32'd5, "R5 single winner");
        expect_irq(1'b1, "R6 irq on eligible");
        wr(12'h044, 32'h0000_0020);
        tick(2);
        expect_rd(12'h040, 32'h0, "R8 held high no re-set");
        expect_irq(1'b0, "R6 irq drops");
        src_req[5] = 1'b0;
        tick(1);
        src_req[5] = 1'b1;
        tick(2);
        expect_rd(12'h040, 32'h0000_0020, "R8 second edge");

        // R5 arbitration: source 3 with equal priority
        wr(12'h148, 32'h0800_0000);
        wr(12'h0C8, 32'h0000_0008);
        src_req[3] = 1'b1;
        tick(3);
        expect_rd(12'h020, 32'd3, "R5 tie lowest number");
        wr(12'h158, 32'h0000_0100);
        tick(2);
        expect_rd(12'h020, 32'd5, "R5 higher value wins");
        wr(12'h154, 32'h0000_1F00);
        tick(2);
        expect_rd(12'h020, 32'd3, "R5 zero priority ignored");
        wr(12'h0C4, 32'h0000_0008);
        tick(2);
        expect_irq(1'b0, "R6 disabled source no irq");
        expect_rd(12'h020, 32'd0, "R5 status zero when idle");
        expect_rd(12'h0C0, 32'h0000_0020, "R2 enable register");
        expect_rd(12'h040, 32'h0000_0028, "R6 flags kept while masked");
        wr(12'h040, 32'h0);
        expect_rd(12'h040, 32'h0, "R3 base write clears flags");
        wr(12'h048, 32'h0000_0001);
        expect_rd(12'h040, 32'h0000_0001, "R3 flag set alias");
        wr(12'h044, 32'h0000_0001);

        // R7 level source 40: flag reg 1 bit 8, pri reg 10 lane 0
        wr(12'h0D8, 32'h0000_0100);
        wr(12'h1E0, 32'h0000_0004);
        src_req[40] = 1'b1;
        tick(3);
        expect_rd(12'h050, 32'h0000_0100, "R7 level sets flag");
        expect_irq(1'b1, "R6 level irq");
        expect_rd(12'h020, 32'd40, "R5 level vector");
        wr(12'h054, 32'h0000_0100);
        expect_rd(12'h050, 32'h0000_0100, "R7 clear ignored while high");
        src_req[40] = 1'b0;
        tick(1);
        expect_rd(12'h050, 32'h0000_0100, "R7 flag latched after drop");
        wr(12'h054, 32'h0000_0100);
        expect_rd(12'h050, 32'h0, "R7 clear after drop");
        tick(2);
        expect_irq(1'b0, "R6 irq after level clear");

        // R9 external pin 2 -> source 58, flag reg 1 bit 26
        src_req[58] = 1'b1;
        tick(3);
        src_req[58] = 1'b0;
        expect_rd(12'h050, 32'h0, "R9 src_req of ext source ignored");
        ext_pin[2] = 1'b1;
        tick(5);
        expect_rd(12'h050, 32'h0, "R9 rise ignored when falling selected");
        tick(1);
        ext_pin[2] = 1'b0;
        tick(2);
        expect_rd(12'h050, 32'h0, "R9 not before third edge");
        tick(1);
        expect_rd(12'h050, 32'h0400_0000, "R9 falling edge at third edge");
        wr(12'h054, 32'h0400_0000);
        wr(12'h008, 32'h0000_0004);
        expect_rd(12'h000, 32'h0000_0004, "R9 polarity bit set");
        tick(1);
        ext_pin[2] = 1'b1;
        tick(2);
        expect_rd(12'h050, 32'h0, "R9 rising not before third edge");
        tick(1);
        expect_rd(12'h050, 32'h0400_0000, "R9 rising edge detected");
        wr(12'h054, 32'h0400_0000);
        ext_pin[2] = 1'b0;
        tick(5);
        expect_rd(12'h050, 32'h0, "R9 fall ignored when rising selected");

        tick(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule